// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the target side of a two-wire serial EEPROM. It runs on the system clock and oversamples the open-drain clock and data lines. From those samples it finds bus start and stop conditions. It then takes in a device select byte, which carries both a chip-select comparison and the top memory address bits. The block answers by pulling the data line low during each acknowledge clock. The storage is a byte array held in flip-flops. It holds 512 bytes for the 4K density and 1024 bytes for the 8K density, chosen by a parameter.

A byte write follows a fixed order: device byte, word address and one data byte, each acknowledged, then a stop from the master. The stop starts a self-timed write cycle. While that cycle runs, the block listens to nothing on the bus. The array is updated only when the cycle ends. Reads start from an internal address counter. A random read loads the counter through a write header that carries no data, then uses a repeated start. A sequential read keeps sending bytes for as long as the master acknowledges. Only the hard-wired select pins that the chosen density compares are ports. The pins that density leaves unconnected do not exist on the block.

Top module: `serial_eeprom_slave`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high, both judged on two-flop synchronized copies of the lines. Every transfer begins with a device byte received after a start.
- R2: The device byte's bits 7..4 must be 1010. Otherwise the block gives no acknowledge, returns to standby and ignores the bus until the next start.
- R3: With DENSITY_KB=4, device byte bits 3 and 2 must equal chip_sel_i[1] (pin A2) and chip_sel_i[0] (pin A1). Bit 1 supplies memory address bit 8.
- R4: With DENSITY_KB=8, device byte bit 3 must equal chip_sel_i[0] (pin A2). Bits 2 and 1 supply memory address bits 9 and 8.
- R5: Device byte bit 0 picks the operation: 1 is a read and 0 is a write.
- R6: After a matching device byte, a word address byte and a write data byte, sda_drv_n_o is 0 for the whole following SCL clock. On sda_drv_n_o, 0 pulls SDA low and 1 releases it. The block never drives SDA high.
- R7: Device byte (write), word address, one data byte, then a stop stores the data at address {page bits, word address}.
- R8: The stop after the data byte starts a write cycle of WR_CYCLES system clocks. During it the block gives no acknowledge, keeps SDA released and ignores all bus activity. The array is written when the cycle ends.
- R9: A start or stop that arrives before a byte is complete aborts the transfer. No write cycle starts and the array is not changed.
- R10: Random read: a write header with a word address, then a repeated start and a read device byte, returns the byte at that address.
- R11: In a read, each byte the master acknowledges is followed by the next address. The address wraps from the last byte of the array to 0. After a master no-acknowledge the block releases SDA and goes to standby.
- R12: sda_drv_n_o changes only while SCL is low.
- R13: After a byte write the address counter points to the following byte, so a read with no word address returns that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| chip_sel_i | input | SEL_W (2 for 4K, 1 for 8K) | Hard-wired select pins: {A2,A1} for 4K, A2 for 8K |
| sda_drv_n_o | output | 1 | Data line pull-down enable, 0 pulls SDA low |

## Verification
On every cycle, the assertions check three things. The data line output moves only while SCL is low. The line stays released for the whole write cycle. The write timer's completion arrives only in the busy state and never overruns its count. The bench scenarios cover the rest: page bits landing at the correct array address for both densities, wrong device bytes drawing no acknowledge, an aborted data byte leaving storage untouched, NACK during the write cycle, and sequential reads wrapping through the top of the array.

// File: rtl/eep_pkg.sv
package eep_pkg;

  localparam logic [3:0] DEV_PREAMBLE = 4'b1010;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DEV,
    S_DEV_ACK,
    S_WADR,
    S_WADR_ACK,
    S_WDAT,
    S_WDAT_ACK,
    S_WAIT_STOP,
    S_RDAT,
    S_RACK,
    S_BUSY
  } eep_state_t;

endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_h,
  output logic sda_l,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);

  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_ff[1];
      sda_q  <= sda_ff[1];
    end
  end

  assign scl_h    = scl_ff[1];
  assign sda_l    = sda_ff[1];
  assign ev_start = scl_h & scl_q & sda_q & ~sda_l;
  assign ev_stop  = scl_h & scl_q & ~sda_q & sda_l;
  assign ev_rise  = scl_h & ~scl_q;
  assign ev_fall  = ~scl_h & scl_q;

endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
  parameter int WR_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic done
);

  localparam int TW = $clog2(WR_CYCLES + 1);
  localparam logic [TW-1:0] LAST = TW'(WR_CYCLES - 1);

  logic          busy_q, busy_n;
  logic [TW-1:0] cnt_q, cnt_n;

  assign done = busy_q && (cnt_q == LAST);

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    if (go) begin
      busy_n = 1'b1;
      cnt_n  = '0;
    end else if (done) begin
      busy_n = 1'b0;
    end else if (busy_q) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
    end
  end

  a_r8_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= LAST));

endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int AW    = 9,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_h,
  input  logic             sda_l,
  input  logic             ev_start,
  input  logic             ev_stop,
  input  logic             ev_rise,
  input  logic             ev_fall,
  input  logic [SEL_W-1:0] chip_sel,
  input  logic [7:0]       rd_byte,
  input  logic             tmr_done,
  output logic             tmr_go,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [7:0]       mem_wdata,
  output logic             sda_drv_n
);

  localparam int PAGE_W = AW - 8;

  eep_state_t    st_q, st_n;
  logic [3:0]    cnt_q, cnt_n;
  logic [7:0]    sh_q, sh_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [7:0]    wd_q, wd_n;
  logic          rw_q, rw_n;
  logic          mack_q, mack_n;
  logic          dev_hit;
  logic          rx_state;

  assign dev_hit  = (sh_q[7:4] == DEV_PREAMBLE) && (sh_q[3 -: SEL_W] == chip_sel);
  assign rx_state = (st_q == S_DEV) || (st_q == S_WADR) || (st_q == S_WDAT);

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    addr_n = addr_q;
    wd_n   = wd_q;
    rw_n   = rw_q;
    mack_n = mack_q;
    tmr_go = 1'b0;
    mem_we = 1'b0;
    if (st_q == S_BUSY) begin
      if (tmr_done) begin
        mem_we = 1'b1;
        addr_n = addr_q + 1'b1;
        st_n   = S_IDLE;
      end
    end else if (ev_start) begin
      st_n  = S_DEV;
      cnt_n = '0;
    end else if (ev_stop) begin
      if (st_q == S_WAIT_STOP) begin
        st_n   = S_BUSY;
        tmr_go = 1'b1;
      end else begin
        st_n = S_IDLE;
      end
    end else if (rx_state) begin
      if (ev_rise && (cnt_q < 4'd8)) begin
        sh_n  = {sh_q[6:0], sda_l};
        cnt_n = cnt_q + 1'b1;
      end else if (ev_fall && (cnt_q == 4'd8)) begin
        unique case (st_q)
          S_DEV: begin
            if (dev_hit) begin
              addr_n[AW-1:8] = sh_q[PAGE_W:1];
              rw_n           = sh_q[0];
              st_n           = S_DEV_ACK;
            end else begin
              st_n = S_IDLE;
            end
          end
          S_WADR: begin
            addr_n[7:0] = sh_q;
            st_n        = S_WADR_ACK;
          end
          default: begin
            wd_n = sh_q;
            st_n = S_WDAT_ACK;
          end
        endcase
      end
    end else if (ev_fall) begin
      unique case (st_q)
        S_DEV_ACK: begin
          cnt_n = '0;
          if (rw_q) begin
            sh_n = rd_byte;
            st_n = S_RDAT;
          end else begin
            st_n = S_WADR;
          end
        end
        S_WADR_ACK: begin
          cnt_n = '0;
          st_n  = S_WDAT;
        end
        S_WDAT_ACK: st_n = S_WAIT_STOP;
        S_RDAT: begin
          if (cnt_q == 4'd7) begin
            addr_n = addr_q + 1'b1;
            st_n   = S_RACK;
          end else begin
            sh_n  = {sh_q[6:0], 1'b0};
            cnt_n = cnt_q + 1'b1;
          end
        end
        S_RACK: begin
          if (mack_q) begin
            sh_n  = rd_byte;
            cnt_n = '0;
            st_n  = S_RDAT;
          end else begin
            st_n = S_IDLE;
          end
        end
        default: st_n = st_q;
      endcase
    end else if (ev_rise && (st_q == S_RACK)) begin
      mack_n = ~sda_l;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      addr_q <= '0;
      wd_q   <= '0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      addr_q <= addr_n;
      wd_q   <= wd_n;
      rw_q   <= rw_n;
      mack_q <= mack_n;
    end
  end

  always_comb begin
    unique case (st_q)
      S_DEV_ACK, S_WADR_ACK, S_WDAT_ACK: sda_drv_n = 1'b0;
      S_RDAT:                            sda_drv_n = sh_q[7];
      default:                           sda_drv_n = 1'b1;
    endcase
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = wd_q;

  a_r12_sda_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_h && $past(scl_h) && !ev_start && !ev_stop) |-> $stable(sda_drv_n));

  a_r8_released_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_BUSY) |-> sda_drv_n);

  a_r8_done_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_done |-> (st_q == S_BUSY));

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave #(
  parameter int DENSITY_KB = 4,
  parameter int WR_CYCLES  = 1000000,
  localparam int DEPTH     = DENSITY_KB * 128,
  localparam int AW        = $clog2(DEPTH),
  localparam int SEL_W     = 11 - AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [SEL_W-1:0] chip_sel_i,
  output logic             sda_drv_n_o
);

  logic [1:0]    rst_ff;
  logic          rst_s_n;
  logic          scl_h, sda_l, ev_start, ev_stop, ev_rise, ev_fall;
  logic          tmr_go, tmr_done, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_s_n = rst_ff[1];

  eep_bus_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_h    (scl_h),
    .sda_l    (sda_l),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .ev_rise  (ev_rise),
    .ev_fall  (ev_fall)
  );

  eep_ctrl #(.AW(AW), .SEL_W(SEL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .scl_h     (scl_h),
    .sda_l     (sda_l),
    .ev_start  (ev_start),
    .ev_stop   (ev_stop),
    .ev_rise   (ev_rise),
    .ev_fall   (ev_fall),
    .chip_sel  (chip_sel_i),
    .rd_byte   (mem_rdata),
    .tmr_done  (tmr_done),
    .tmr_go    (tmr_go),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .sda_drv_n (sda_drv_n_o)
  );

  eep_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_s_n),
    .go    (tmr_go),
    .done  (tmr_done)
  );

  eep_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

endmodule

// File: tb/serial_eeprom_slave_bench.sv
module serial_eeprom_slave_bench;

  localparam int WRC = 1000;
  localparam int Q   = 10;

  // {select 8K, address, data}
  localparam logic [18:0] VEC [0:7] = '{
    {1'b0, 10'h000, 8'h11}, {1'b0, 10'h1FF, 8'hEE},
    {1'b0, 10'h0AB, 8'h5A}, {1'b0, 10'h1AB, 8'hA5},
    {1'b1, 10'h2AB, 8'h3C}, {1'b1, 10'h3AB, 8'hC3},
    {1'b1, 10'h0AB, 8'h77}, {1'b1, 10'h1FF, 8'h99}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic drv4, drv8;
  wire  sda_bus = sda_m & drv4 & drv8;
  int   n_cmp = 0;
  int   n_bad = 0;
  int   r12_viol = 0;
  logic scl_p = 1'b1, p4 = 1'b1, p8 = 1'b1;

  always #2.5 clk = ~clk;

  serial_eeprom_slave #(.DENSITY_KB(4), .WR_CYCLES(WRC)) u_serial_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .chip_sel_i(2'b00), .sda_drv_n_o(drv4));

  serial_eeprom_slave #(.DENSITY_KB(8), .WR_CYCLES(WRC)) u_serial_eeprom_slave_8k (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .chip_sel_i(1'b1), .sda_drv_n_o(drv8));

  // R12 monitor: output may only move while SCL is low
  always @(negedge clk) begin
    if (rst_n && scl_m && scl_p && ((drv4 != p4) || (drv8 != p8))) r12_viol++;
    scl_p <= scl_m; p4 <= drv4; p8 <= drv8;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] dev(input logic sel, input logic [9:0] a, input logic rd);
    if (sel) return {4'hA, 1'b1, a[9:8], rd};
    else     return {4'hA, 2'b00, a[8], rd};
  endfunction

  task automatic b_start;
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic b_stop;
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic b_bit(input logic b, output logic s);
    sda_m = b; w(Q); scl_m = 1'b1; w(Q); s = sda_bus; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic w_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) b_bit(d[i], s);
    b_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic r_byte(input logic give_ack, output logic [7:0] d);
    logic s;
    for (int i = 0; i < 8; i++) begin
      b_bit(1'b1, s);
      d = {d[6:0], s};
    end
    b_bit(~give_ack, s);
  endtask

  task automatic wr(input logic sel, input logic [9:0] a, input logic [7:0] d,
                    input logic wait_done, output logic ok);
    logic a0, a1, a2;
    b_start;
    w_byte(dev(sel, a, 1'b0), a0);
    w_byte(a[7:0], a1);
    w_byte(d, a2);
    b_stop;
    ok = a0 & a1 & a2;
    if (wait_done) w(WRC + 40);
  endtask

  task automatic rd(input logic sel, input logic [9:0] a, output logic [7:0] d);
    logic k;
    b_start;
    w_byte(dev(sel, a, 1'b0), k);
    w_byte(a[7:0], k);
    b_start;
    w_byte(dev(sel, a, 1'b1), k);
    r_byte(1'b0, d);
    b_stop;
  endtask

  task automatic finish_run;
    chk("R12 SDA moved while SCL high", r12_viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R1 watchdog expired: got 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic       ok, k;
    logic [7:0] d;
    w(8);
    chk("R6 reset 4K released", int'(drv4), 1);
    chk("R6 reset 8K released", int'(drv8), 1);
    rst_n = 1'b1;
    w(10);

    // Vector table: byte writes then random reads (R1 R3 R4 R5 R6 R7 R10)
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][18], VEC[i][17:8], VEC[i][7:0], 1'b1, ok);
      chk($sformatf("R6 R7 write acks vec %0d", i), int'(ok), 1);
    end
    for (int i = 0; i < 8; i++) begin
      rd(VEC[i][18], VEC[i][17:8], d);
      chk($sformatf("R3 R4 R10 readback vec %0d", i), int'(d), int'(VEC[i][7:0]));
    end

    // R2: wrong preamble, no acknowledge
    b_start; w_byte(8'hB0, k); b_stop;
    chk("R2 bad preamble nack", int'(k), 0);
    // R3: select bit mismatch on both devices
    b_start; w_byte(8'hA4, k); b_stop;
    chk("R3 select mismatch nack", int'(k), 0);

    // R8: write cycle is deaf, array updated when it ends
    wr(1'b0, 10'h010, 8'h42, 1'b0, ok);
    chk("R7 write 0x010 acks", int'(ok), 1);
    b_start; w_byte(dev(1'b0, 10'h010, 1'b0), k); b_stop;
    chk("R8 nack during write cycle", int'(k), 0);
    w(WRC + 40);
    rd(1'b0, 10'h010, d);
    chk("R8 data present after cycle", int'(d), 8'h42);

    // R9: stop inside the data byte aborts
    b_start;
    w_byte(dev(1'b0, 10'h010, 1'b0), k);
    w_byte(8'h10, k);
    for (int i = 0; i < 4; i++) b_bit(1'b1, k);
    b_stop;
    b_start; w_byte(dev(1'b0, 10'h010, 1'b0), k); b_stop;
    chk("R9 no write cycle after abort", int'(k), 1);
    rd(1'b0, 10'h010, d);
    chk("R9 array unchanged", int'(d), 8'h42);

    // R11: sequential read wraps 0x1FF -> 0x000, release on nack
    b_start;
    w_byte(dev(1'b0, 10'h1FF, 1'b0), k);
    w_byte(8'hFF, k);
    b_start;
    w_byte(dev(1'b0, 10'h1FF, 1'b1), k);
    chk("R5 read device byte ack", int'(k), 1);
    r_byte(1'b1, d);
    chk("R11 first byte 0x1FF", int'(d), 8'hEE);
    r_byte(1'b0, d);
    chk("R11 wrapped byte 0x000", int'(d), 8'h11);
    chk("R11 released after nack", int'(drv4), 1);
    b_stop;

    // R13: current address read after a byte write
    wr(1'b0, 10'h0AA, 8'h66, 1'b1, ok);
    chk("R13 write 0x0AA acks", int'(ok), 1);
    b_start;
    w_byte(dev(1'b0, 10'h0AA, 1'b1), k);
    r_byte(1'b0, d);
    b_stop;
    chk("R13 current address gives 0x0AB", int'(d), 8'h5A);

    w(20);
    finish_run;
  end

endmodule